// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block decides which of several transmit buffers is handed next to a CAN protocol engine. It then follows that frame until the engine reports how the attempt ended. Software raises a request with a write strobe. A dedicated request input, one per buffer, can raise the same request on its rising edge. Each buffer carries a 2-bit priority. Whenever no frame is in flight, the scheduler picks the pending buffer with the highest priority, drives its index and issues a one-cycle start strobe.

The engine answers with a single pulse: success, lost arbitration or bus error. A success retires the request and sets that buffer's transmit-complete flag, which raises the interrupt line if it is enabled. A failed attempt sets a sticky status flag. In normal mode the buffer then stays pending and competes again. In one-shot mode, or when a global abort arrived during the attempt, the request is retired as aborted. A global abort drops every pending request at once, except the frame on the bus. That frame is allowed to finish and is only cancelled if it fails.

Top module: `tx_sched`

## Requirements
- R1: A request bit is set by a one-cycle `req_set` strobe or by a rising edge on `req_pin` (a held high level makes one request only). Only buffers whose request bit is set are ever started. Bit i of every per-buffer vector belongs to buffer i.
- R2: Buffer i's priority is `prio[2i+1:2i]`, with 3 the highest and 0 the lowest. The scheduler starts the pending buffer with the highest value. On a tie it starts the higher-numbered buffer.
- R3: At most one frame is in flight. `start` is a one-cycle pulse in the cycle after the choice, with `sel` valid and `busy` high. `sel` holds and no further start occurs until the engine reports a completion, so priority changes made during the flight have no effect on the frame in flight.
- R4: On `done_ok`, the in-flight buffer's request bit clears and its `txif` bit sets. `irq` is high while any `txif` bit is set together with its `irq_en` bit.
- R5: On `done_lost`, `lost_flag` of the in-flight buffer sets. In normal mode the buffer stays pending and is started again.
- R6: On `done_err`, `err_flag` of the in-flight buffer sets. In normal mode the buffer stays pending and is started again.
- R7: `abort_all` clears every request bit that is not in flight and sets `abort_flag` for each bit it cleared. A request raised in the same cycle as the abort is dropped.
- R8: A buffer in flight during an abort keeps transmitting. If it succeeds, it completes as in R4 with no abort flag. If it fails, its request clears and `abort_flag` sets with no retry.
- R9: With `one_shot` high, any completion retires the request. A failed attempt also sets `abort_flag` and is not retried.
- R10: `flag_clr[i]` clears `txif`, `lost_flag`, `err_flag` and `abort_flag` of buffer i. A completion event in the same cycle takes precedence.
- R11: Completion pulses arriving while no frame is in flight have no effect.
- R12: After reset, `start`, `busy`, `irq` and all request bits and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | N | Per-buffer request write strobe |
| req_pin | input | N | Per-buffer request input, acts on rising edge |
| prio | input | N*PW | Packed per-buffer priorities |
| abort_all | input | 1 | Global abort strobe |
| one_shot | input | 1 | Single attempt per frame when high |
| irq_en | input | N | Per-buffer completion interrupt enable |
| flag_clr | input | N | Per-buffer flag clear strobe |
| done_ok | input | 1 | Engine: frame sent successfully |
| done_lost | input | 1 | Engine: arbitration lost |
| done_err | input | 1 | Engine: bus error during frame |
| start | output | 1 | One-cycle strobe: hand `sel` to the engine |
| sel | output | $clog2(N) | Index of the buffer in flight |
| busy | output | 1 | A frame is in flight |
| req_pend | output | N | Pending request bits |
| lost_flag | output | N | Sticky lost-arbitration flags |
| err_flag | output | N | Sticky transmit-error flags |
| abort_flag | output | N | Sticky aborted flags |
| txif | output | N | Transmit-complete flags |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with three buffers and 2-bit priorities, which are the default values. This reaches every priority level, both tie directions, and an abort that splits the pending set into the frame in flight plus two dropped buffers. Expected start indices are queued by the stimulus and compared on every strobe. The bench also covers retries after lost arbitration and after an error, one-shot retirement, a request arriving in the same cycle as an abort, and a request input held high across a whole frame.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_OK   = 2'd1,
    EV_LOST = 2'd2,
    EV_ERR  = 2'd3
  } tx_evt_e;
endpackage

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best_p;

  // Linear scan; ">=" lets a later (higher-numbered) buffer win ties.
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    best_p = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i*PW +: PW] >= best_p)) begin
        found  = 1'b1;
        idx    = IW'(i);
        best_p = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/tx_buf_slot.sv
module tx_buf_slot
  import tx_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    set_req,
  input  logic    kill_req,
  input  tx_evt_e evt,
  input  logic    one_shot,
  input  logic    abort_pend,
  input  logic    flag_clr,
  output logic    req_q,
  output logic    lost_q,
  output logic    err_q,
  output logic    abrt_q,
  output logic    txif_q
);
  logic failed, retire_fail;

  assign failed      = (evt == EV_LOST) || (evt == EV_ERR);
  assign retire_fail = failed && (one_shot || abort_pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      lost_q <= 1'b0;
      err_q  <= 1'b0;
      abrt_q <= 1'b0;
      txif_q <= 1'b0;
    end else begin
      if (kill_req)
        req_q <= 1'b0;
      else if (set_req)
        req_q <= 1'b1;
      else if (evt == EV_OK || retire_fail)
        req_q <= 1'b0;

      if (evt == EV_LOST)    lost_q <= 1'b1;
      else if (flag_clr)     lost_q <= 1'b0;

      if (evt == EV_ERR)     err_q <= 1'b1;
      else if (flag_clr)     err_q <= 1'b0;

      if (evt == EV_OK)      txif_q <= 1'b1;
      else if (flag_clr)     txif_q <= 1'b0;

      if (retire_fail || (kill_req && req_q)) abrt_q <= 1'b1;
      else if (flag_clr)                      abrt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_sched.sv
module tx_sched
  import tx_sched_pkg::*;
#(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_set,
  input  logic [N-1:0]    req_pin,
  input  logic [N*PW-1:0] prio,
  input  logic            abort_all,
  input  logic            one_shot,
  input  logic [N-1:0]    irq_en,
  input  logic [N-1:0]    flag_clr,
  input  logic            done_ok,
  input  logic            done_lost,
  input  logic            done_err,
  output logic            start,
  output logic [IW-1:0]   sel,
  output logic            busy,
  output logic [N-1:0]    req_pend,
  output logic [N-1:0]    lost_flag,
  output logic [N-1:0]    err_flag,
  output logic [N-1:0]    abort_flag,
  output logic [N-1:0]    txif,
  output logic            irq
);
  logic [N-1:0]  pin_q;
  logic [N-1:0]  set_vec;
  logic          busy_q, abort_pend_q, start_q;
  logic [IW-1:0] sel_q;
  logic          pick_found;
  logic [IW-1:0] pick_idx;
  logic          any_done;
  tx_evt_e       done_kind;

  assign set_vec  = req_set | (req_pin & ~pin_q);
  assign any_done = busy_q && (done_ok || done_lost || done_err);

  always_comb begin
    if (done_ok)        done_kind = EV_OK;
    else if (done_err)  done_kind = EV_ERR;
    else if (done_lost) done_kind = EV_LOST;
    else                done_kind = EV_NONE;
  end

  tx_prio_pick #(.N(N), .PW(PW)) u_pick (
    .cand  (req_pend),
    .prio  (prio),
    .found (pick_found),
    .idx   (pick_idx)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic    in_flight;
    tx_evt_e evt;
    assign in_flight = busy_q && (sel_q == IW'(i));
    assign evt       = in_flight ? done_kind : EV_NONE;

    tx_buf_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .set_req    (set_vec[i]),
      .kill_req   (abort_all && !in_flight),
      .evt        (evt),
      .one_shot   (one_shot),
      .abort_pend (abort_pend_q || abort_all),
      .flag_clr   (flag_clr[i]),
      .req_q      (req_pend[i]),
      .lost_q     (lost_flag[i]),
      .err_q      (err_flag[i]),
      .abrt_q     (abort_flag[i]),
      .txif_q     (txif[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q        <= '0;
      busy_q       <= 1'b0;
      abort_pend_q <= 1'b0;
      start_q      <= 1'b0;
      sel_q        <= '0;
    end else begin
      pin_q   <= req_pin;
      start_q <= 1'b0;
      if (busy_q) begin
        if (any_done) begin
          busy_q       <= 1'b0;
          abort_pend_q <= 1'b0;
        end else if (abort_all) begin
          abort_pend_q <= 1'b1;
        end
      end else if (pick_found && !abort_all) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        sel_q   <= pick_idx;
      end
    end
  end

  assign start = start_q;
  assign sel   = sel_q;
  assign busy  = busy_q;
  assign irq   = |(txif & irq_en);
endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    req_set,
  input logic [N-1:0]    req_pin,
  input logic [N*PW-1:0] prio,
  input logic            abort_all,
  input logic            one_shot,
  input logic [N-1:0]    flag_clr,
  input logic            done_ok,
  input logic            done_lost,
  input logic            done_err,
  input logic            start,
  input logic [IW-1:0]   sel,
  input logic            busy,
  input logic [N-1:0]    req_pend,
  input logic [N-1:0]    lost_flag,
  input logic [N-1:0]    err_flag,
  input logic [N-1:0]    abort_flag,
  input logic [N-1:0]    txif
);
  logic [N-1:0]    p_req;
  logic [N*PW-1:0] p_prio;
  logic            better;
  logic            any_done;

  assign any_done = done_ok || done_lost || done_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_req  <= '0;
      p_prio <= '0;
    end else begin
      p_req  <= req_pend;
      p_prio <= prio;
    end
  end

  always_comb begin
    better = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (p_req[i] && (IW'(i) != sel)) begin
        if (p_prio[i*PW +: PW] > p_prio[int'(sel)*PW +: PW])
          better = 1'b1;
        else if (p_prio[i*PW +: PW] == p_prio[int'(sel)*PW +: PW] && IW'(i) > sel)
          better = 1'b1;
      end
    end
  end

  assert_start_pending_R1: assert property (@(posedge clk) disable iff (rst)
    start |-> p_req[sel]);

  assert_best_choice_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> !better);

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  assert_start_from_idle_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> busy && !$past(busy));

  assert_hold_in_flight_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !any_done) |=> busy && $stable(sel) && !start);

  assert_ok_retires_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && done_ok && !req_set[sel] && !req_pin[sel])
    |=> !req_pend[$past(sel)] && txif[$past(sel)]);

  assert_lost_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && done_lost) |=> lost_flag[$past(sel)]);

  assert_err_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && done_err) |=> err_flag[$past(sel)]);

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (abort_all && !busy) |=> req_pend == '0);

  assert_one_shot_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done_ok && (done_lost || done_err) && one_shot
     && !req_set[sel] && !req_pin[sel])
    |=> !req_pend[$past(sel)] && abort_flag[$past(sel)]);

  for (genvar i = 0; i < N; i++) begin : g_clr
    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[i] && !busy)
      |=> !txif[i] && !lost_flag[i] && !err_flag[i] && !abort_flag[i]);
  end

  assert_idle_done_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && flag_clr == '0)
    |=> $stable(txif) && $stable(lost_flag) && $stable(err_flag));
endmodule

bind tx_sched tx_sched_chk #(.N(N), .PW(PW)) u_chk (.*);

// File: tb/tb_tx_sched.sv
`timescale 1ns/1ps
module tb_tx_sched;
  localparam int N  = 3;
  localparam int PW = 2;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    req_set, req_pin, irq_en, flag_clr;
  logic [N*PW-1:0] prio;
  logic            abort_all, one_shot, done_ok, done_lost, done_err;
  logic            start, busy, irq;
  logic [IW-1:0]   sel;
  logic [N-1:0]    req_pend, lost_flag, err_flag, abort_flag, txif;

  int tests = 0;
  int fails = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  tx_sched #(.N(N), .PW(PW)) dut (
    .clk(clk), .rst(rst), .req_set(req_set), .req_pin(req_pin), .prio(prio),
    .abort_all(abort_all), .one_shot(one_shot), .irq_en(irq_en),
    .flag_clr(flag_clr), .done_ok(done_ok), .done_lost(done_lost),
    .done_err(done_err), .start(start), .sel(sel), .busy(busy),
    .req_pend(req_pend), .lost_flag(lost_flag), .err_flag(err_flag),
    .abort_flag(abort_flag), .txif(txif), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every start strobe must match the next queued index.
  always @(negedge clk) begin
    if (!rst && start) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected start", int'(sel), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(sel) == e, "R2 start order", int'(sel), e);
      end
    end
  end

  task automatic pulse_set(input logic [N-1:0] m);
    @(negedge clk); req_set = m;
    @(negedge clk); req_set = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = '1;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic wait_start();
    int n = 0;
    while (!start && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(start, "R3 start seen", int'(start), 1);
  endtask

  // 0 = ok, 1 = lost, 2 = error
  task automatic complete(input int kind);
    done_ok   = (kind == 0);
    done_lost = (kind == 1);
    done_err  = (kind == 2);
    @(negedge clk);
    done_ok = 1'b0; done_lost = 1'b0; done_err = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #500000;
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_set = '0; req_pin = '0; irq_en = '0; flag_clr = '0;
    prio = '0; abort_all = 1'b0; one_shot = 1'b0;
    done_ok = 1'b0; done_lost = 1'b0; done_err = 1'b0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!start && !busy && !irq, "R12 idle outputs", int'({start, busy, irq}), 0);
    check(req_pend == 0 && txif == 0 && lost_flag == 0 && err_flag == 0 && abort_flag == 0,
          "R12 flags", int'(req_pend | txif | lost_flag | err_flag | abort_flag), 0);

    // R1/R2/R4: priorities buf2=2, buf1=3, buf0=1
    prio = {2'd2, 2'd3, 2'd1};
    irq_en = 3'b010;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(0);
    pulse_set(3'b111);
    check(req_pend == 3'b111 && !start, "R1 requests latched", int'(req_pend), 7);
    wait_start();
    complete(0);
    check(req_pend == 3'b101 && txif == 3'b010, "R4 success retires", int'(req_pend), 5);
    check(irq, "R4 irq enabled", int'(irq), 1);
    wait_start(); complete(0);
    wait_start(); complete(0);
    check(req_pend == 0 && txif == 3'b111, "R4 all sent", int'(txif), 7);

    // R10 flag clear
    pulse_clr();
    check(txif == 0 && !irq, "R10 clear txif", int'(txif), 0);

    // R2 tie: equal priorities, higher index first
    prio = {2'd2, 2'd2, 2'd2};
    exp_q.push_back(2); exp_q.push_back(0);
    pulse_set(3'b101);
    wait_start(); complete(0);
    wait_start(); complete(0);

    // R3 priority change during flight has no effect
    prio = {2'd0, 2'd1, 2'd0};
    exp_q.push_back(1); exp_q.push_back(0);
    pulse_set(3'b011);
    wait_start();
    @(negedge clk);
    prio = {2'd0, 2'd1, 2'd3};
    check(!start && busy && sel == 1, "R3 hold in flight", int'(sel), 1);
    idle(4);
    check(busy && sel == 1 && !start, "R3 still in flight", int'(sel), 1);
    complete(0);
    wait_start(); complete(0);
    pulse_clr();

    // R5 lost arbitration retries
    exp_q.push_back(2); exp_q.push_back(2);
    pulse_set(3'b100);
    wait_start();
    complete(1);
    check(lost_flag == 3'b100 && req_pend == 3'b100, "R5 lost flag and pending", int'(lost_flag), 4);
    wait_start(); complete(0);
    check(lost_flag[2] && txif[2] && req_pend == 0, "R5 retry succeeded", int'(req_pend), 0);

    // R6 error retries
    exp_q.push_back(0); exp_q.push_back(0);
    pulse_set(3'b001);
    wait_start();
    complete(2);
    check(err_flag == 3'b001 && req_pend == 3'b001, "R6 error flag and pending", int'(err_flag), 1);
    wait_start(); complete(0);
    pulse_clr();

    // R9 one-shot
    one_shot = 1'b1;
    exp_q.push_back(1);
    pulse_set(3'b010);
    wait_start();
    complete(1);
    check(req_pend == 0 && abort_flag == 3'b010 && lost_flag == 3'b010,
          "R9 one-shot failure retired", int'(abort_flag), 2);
    idle(5);
    check(!busy, "R9 no retry", int'(busy), 0);
    exp_q.push_back(0);
    pulse_set(3'b001);
    wait_start();
    complete(0);
    check(req_pend == 0 && txif[0] && !abort_flag[0], "R9 one-shot success", int'(txif), 1);
    one_shot = 1'b0;
    pulse_clr();

    // R7/R8 abort with buf0 in flight, buf1/buf2 pending
    prio = {2'd0, 2'd0, 2'd3};
    exp_q.push_back(0);
    pulse_set(3'b111);
    wait_start();
    abort_all = 1'b1;
    @(negedge clk);
    abort_all = 1'b0;
    check(req_pend == 3'b001 && abort_flag == 3'b110 && busy, "R7 abort drops pending",
          int'(req_pend), 1);
    idle(3);
    complete(0);
    check(txif[0] && !abort_flag[0] && req_pend == 0, "R8 in-flight success", int'(abort_flag), 6);
    idle(5);
    check(!busy, "R8 nothing left", int'(busy), 0);

    // R7 request in same cycle as abort is dropped
    @(negedge clk); abort_all = 1'b1; req_set = 3'b010;
    @(negedge clk); abort_all = 1'b0; req_set = '0;
    idle(3);
    check(req_pend == 0 && !busy, "R7 simultaneous request dropped", int'(req_pend), 0);
    pulse_clr();

    // R8 in-flight failure after abort
    exp_q.push_back(2);
    pulse_set(3'b100);
    wait_start();
    abort_all = 1'b1;
    @(negedge clk);
    abort_all = 1'b0;
    complete(2);
    check(req_pend == 0 && abort_flag == 3'b100 && err_flag == 3'b100,
          "R8 failed after abort", int'(abort_flag), 4);
    idle(5);
    check(!busy, "R8 no retry", int'(busy), 0);
    pulse_clr();

    // R1 request pin: held high gives one request
    exp_q.push_back(1);
    @(negedge clk); req_pin = 3'b010;
    wait_start();
    complete(0);
    idle(6);
    check(!busy && req_pend == 0, "R1 held pin single request", int'(req_pend), 0);
    req_pin = '0;
    pulse_clr();

    // R11 completion while idle
    complete(0);
    complete(1);
    complete(2);
    check(txif == 0 && lost_flag == 0 && err_flag == 0 && !busy,
          "R11 idle completion ignored", int'(txif | lost_flag | err_flag), 0);

    idle(4);
    check(exp_q.size() == 0, "R3 all expected starts seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule